// File: doc/BRIEF.md
# Monochrome VGA Scanline Streamer

This block produces a 640x400 one-bit-per-pixel VGA picture from a stream of 32-bit frame-buffer words. A horizontal phase machine and a vertical phase machine cut the dot-clock timeline into scanlines of 800 cycles and frames of 449 lines. During the visible part of each visible line, the block asks its word supplier for a new word at the start of every 32-pixel slot. It then sends that word out one bit per dot clock, most significant bit first. Outside the visible area the pixel output is forced to black. It goes black on the very first cycle after the last visible bit of a line.

The supplier sees a plain valid/ready handshake. `in_ready` depends only on the scan position, never on `in_valid`, and it is high for exactly one cycle per slot. The supplier must offer the word in that cycle. If no word is offered, the whole slot is shown black and a sticky underrun flag is raised. A one-cycle rewind strobe fires on the first cycle of vertical sync. It tells the supplier to return its read pointer to the top of the screen, and it also clears the underrun flag. A start-of-line strobe marks pixel position 0 of every line.

The horizontal machine has four states, entered in this order. H_ACT runs until the last visible column and moves to H_FP. H_FP runs until the end of the front porch and moves to H_SYNC. H_SYNC runs until the end of the pulse and moves to H_BP. H_BP runs until the end of the line and returns to H_ACT. The vertical machine has the states V_ACT, V_FP, V_SYNC and V_BP and follows the same ring, but it only advances on the last cycle of a line. The serializer has three states. SH_BLANK moves to SH_SHIFT (word offered) or to SH_STARVE (word missing) when the visible region opens. At each later slot start, SH_SHIFT and SH_STARVE move to SH_SHIFT or SH_STARVE, chosen the same way. When the visible region closes, both return to SH_BLANK.

Top module: `mono_vga_streamer`

## Requirements
- R1: A line lasts H_VIS+H_FRONT+H_PULSE+H_BACK cycles (default 640+16+96+48). `line_start` is high for one cycle at pixel position 0 of every line. `hsync_n` is low (active low) exactly for positions H_VIS+H_FRONT up to H_VIS+H_FRONT+H_PULSE-1.
- R2: A frame lasts V_VIS+V_FRONT+V_PULSE+V_BACK lines (default 400+12+2+35). `vsync` is high (active high) for the whole of lines V_VIS+V_FRONT up to V_VIS+V_FRONT+V_PULSE-1, and it is never high while a visible pixel is shown.
- R3: `in_ready` is high in exactly those cycles whose scan position is visible (column < H_VIS, line < V_VIS) and whose column is a multiple of WORD_W. It is low in all other cycles, and it does not depend on `in_valid`.
- R4: The word accepted for a slot starting at column 32k is shown over columns 32k to 32k+31, with bit 31-j at column 32k+j (MSB first). All outputs for a scan position appear one cycle after the cycle in which `in_ready` was high for that position.
- R5: The pixel is 0 at every position outside the visible area, including the first position after the last visible column.
- R6: `frame_rewind` is high for exactly one cycle, at column 0 of the first vsync line, and it coincides with `line_start` and `vsync`.
- R7: If `in_valid` is low while `in_ready` is high, all WORD_W pixels of that slot are 0. `underrun` then goes high together with the first of those pixels and stays high until it is cleared together with the next `frame_rewind`.
- R8: `in_data` and `in_valid` are ignored in any cycle where `in_ready` is low.
- R9: While reset is active: `pix`=0, `hsync_n`=1, `vsync`=0, `line_start`=0, `frame_rewind`=0, `underrun`=0. After release, the first scan position is column 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Supplier offers a word |
| in_data | input | WORD_W | Frame-buffer word, leftmost pixel in the MSB |
| in_ready | output | 1 | Slot start: the word is taken this cycle |
| pix | output | 1 | Monochrome pixel (1 = white) |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync | output | 1 | Vertical sync, active high |
| line_start | output | 1 | One-cycle strobe at column 0 of every line |
| frame_rewind | output | 1 | One-cycle strobe telling the supplier to return to the top of the screen |
| underrun | output | 1 | Sticky flag for a missed word, cleared on rewind |

## Verification
The bench uses a scaled-down timing (64 visible columns, 6 visible lines) and sweeps every cycle of three complete frames, comparing each output to a value computed from the scan position. The first frame is all white, so any pixel that leaks into the porches or the first column after the visible area shows up at once. The second frame carries a different hashed word in every slot, which exposes bit-order, slot-index and rewind-pointer errors: without the rewind, the supplier's pointer would drift and the words would no longer match. The third frame withholds selected words, including the last slot of the frame, to check blank slots and the sticky flag. Valid garbage is offered whenever `in_ready` is low, to show that such data is ignored.

// File: rtl/mvga_pkg.sv
package mvga_pkg;

    typedef enum logic [1:0] {
        H_ACT,
        H_FP,
        H_SYNC,
        H_BP
    } hphase_e;

    typedef enum logic [1:0] {
        V_ACT,
        V_FP,
        V_SYNC,
        V_BP
    } vphase_e;

    typedef enum logic [1:0] {
        SH_BLANK,
        SH_SHIFT,
        SH_STARVE
    } shift_e;

endpackage

// File: rtl/mvga_line_timer.sv
module mvga_line_timer
    import mvga_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int H_VIS   = 640,
    parameter int H_FRONT = 16,
    parameter int H_PULSE = 96,
    parameter int H_BACK  = 48,
    parameter int V_VIS   = 400,
    parameter int V_FRONT = 12,
    parameter int V_PULSE = 2,
    parameter int V_BACK  = 35
) (
    input  logic clk,
    input  logic rst_n,
    output logic act_c,
    output logic slot_c,
    output logic rewind_c,
    output logic vis_q,
    output logic hsync_n_q,
    output logic vsync_q,
    output logic sol_q,
    output logic sof_q
);

    localparam int HT = H_VIS + H_FRONT + H_PULSE + H_BACK;
    localparam int VT = V_VIS + V_FRONT + V_PULSE + V_BACK;
    localparam int HW = $clog2(HT);
    localparam int VW = $clog2(VT);
    localparam int BW = $clog2(WORD_W);

    localparam logic [HW-1:0] H_LAST_ACT = HW'(H_VIS - 1);
    localparam logic [HW-1:0] H_LAST_FP  = HW'(H_VIS + H_FRONT - 1);
    localparam logic [HW-1:0] H_BEG_SY   = HW'(H_VIS + H_FRONT);
    localparam logic [HW-1:0] H_LAST_SY  = HW'(H_VIS + H_FRONT + H_PULSE - 1);
    localparam logic [HW-1:0] H_LAST_LN  = HW'(HT - 1);
    localparam logic [VW-1:0] V_LAST_ACT = VW'(V_VIS - 1);
    localparam logic [VW-1:0] V_LAST_FP  = VW'(V_VIS + V_FRONT - 1);
    localparam logic [VW-1:0] V_BEG_SY   = VW'(V_VIS + V_FRONT);
    localparam logic [VW-1:0] V_LAST_SY  = VW'(V_VIS + V_FRONT + V_PULSE - 1);
    localparam logic [VW-1:0] V_LAST_FR  = VW'(VT - 1);

    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;
    hphase_e       hst, hst_n;
    vphase_e       vst, vst_n;
    logic          line_end;

    assign line_end = (hcnt == H_LAST_LN);

    always_comb begin
        hst_n = hst;
        unique case (hst)
            H_ACT:  if (hcnt == H_LAST_ACT) hst_n = H_FP;
            H_FP:   if (hcnt == H_LAST_FP)  hst_n = H_SYNC;
            H_SYNC: if (hcnt == H_LAST_SY)  hst_n = H_BP;
            H_BP:   if (line_end)           hst_n = H_ACT;
        endcase
    end

    always_comb begin
        vst_n = vst;
        if (line_end) begin
            unique case (vst)
                V_ACT:  if (vcnt == V_LAST_ACT) vst_n = V_FP;
                V_FP:   if (vcnt == V_LAST_FP)  vst_n = V_SYNC;
                V_SYNC: if (vcnt == V_LAST_SY)  vst_n = V_BP;
                V_BP:   if (vcnt == V_LAST_FR)  vst_n = V_ACT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hst  <= H_ACT;
            vst  <= V_ACT;
            hcnt <= '0;
            vcnt <= '0;
        end else begin
            hst <= hst_n;
            vst <= vst_n;
            if (line_end) begin
                hcnt <= '0;
                vcnt <= (vcnt == V_LAST_FR) ? '0 : vcnt + 1'b1;
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    assign act_c    = (hst == H_ACT) && (vst == V_ACT);
    assign slot_c   = act_c && (hcnt[BW-1:0] == '0);
    assign rewind_c = (hcnt == '0) && (vst == V_SYNC) && (vcnt == V_BEG_SY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vis_q     <= 1'b0;
            hsync_n_q <= 1'b1;
            vsync_q   <= 1'b0;
            sol_q     <= 1'b0;
            sof_q     <= 1'b0;
        end else begin
            vis_q     <= act_c;
            hsync_n_q <= (hst != H_SYNC);
            vsync_q   <= (vst == V_SYNC);
            sol_q     <= (hcnt == '0);
            sof_q     <= rewind_c;
        end
    end

    // R1
    hact_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hst == H_ACT) |-> (hcnt <= H_LAST_ACT));

    // R1
    hpulse_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync_n_q) |-> ($past(hcnt) == H_BEG_SY));

    // R2
    vsync_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_q |-> !vis_q);

endmodule

// File: rtl/mvga_bit_shifter.sv
module mvga_bit_shifter
    import mvga_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_c,
    input  logic              slot_c,
    input  logic              rewind_c,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              pix,
    output logic              underrun
);

    shift_e            st, st_n;
    logic [WORD_W-1:0] shreg;
    logic              take;

    assign take = slot_c && in_valid;

    always_comb begin
        st_n = st;
        unique case (st)
            SH_BLANK: begin
                if (act_c) st_n = in_valid ? SH_SHIFT : SH_STARVE;
            end
            SH_SHIFT, SH_STARVE: begin
                if (!act_c)      st_n = SH_BLANK;
                else if (slot_c) st_n = in_valid ? SH_SHIFT : SH_STARVE;
            end
            default: st_n = SH_BLANK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SH_BLANK;
        else        st <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            underrun <= 1'b0;
        end else begin
            shreg <= take ? in_data : {shreg[WORD_W-2:0], 1'b0};
            if (slot_c && !in_valid) underrun <= 1'b1;
            else if (rewind_c)       underrun <= 1'b0;
        end
    end

    always_comb begin
        pix = (st == SH_SHIFT) && shreg[WORD_W-1];
    end

    // R7
    und_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(slot_c && !in_valid));

    // R7
    starve_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_c && !in_valid) |=> !pix);

endmodule

// File: rtl/mono_vga_streamer.sv
module mono_vga_streamer #(
    parameter int WORD_W  = 32,
    parameter int H_VIS   = 640,
    parameter int H_FRONT = 16,
    parameter int H_PULSE = 96,
    parameter int H_BACK  = 48,
    parameter int V_VIS   = 400,
    parameter int V_FRONT = 12,
    parameter int V_PULSE = 2,
    parameter int V_BACK  = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              pix,
    output logic              hsync_n,
    output logic              vsync,
    output logic              line_start,
    output logic              frame_rewind,
    output logic              underrun
);

    logic act_c;
    logic slot_c;
    logic rewind_c;
    logic vis_q;

    mvga_line_timer #(
        .WORD_W (WORD_W),
        .H_VIS  (H_VIS),
        .H_FRONT(H_FRONT),
        .H_PULSE(H_PULSE),
        .H_BACK (H_BACK),
        .V_VIS  (V_VIS),
        .V_FRONT(V_FRONT),
        .V_PULSE(V_PULSE),
        .V_BACK (V_BACK)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_c    (act_c),
        .slot_c   (slot_c),
        .rewind_c (rewind_c),
        .vis_q    (vis_q),
        .hsync_n_q(hsync_n),
        .vsync_q  (vsync),
        .sol_q    (line_start),
        .sof_q    (frame_rewind)
    );

    mvga_bit_shifter #(
        .WORD_W(WORD_W)
    ) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_c   (act_c),
        .slot_c  (slot_c),
        .rewind_c(rewind_c),
        .in_valid(in_valid),
        .in_data (in_data),
        .pix     (pix),
        .underrun(underrun)
    );

    assign in_ready = slot_c;

    // R5
    blank_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vis_q |-> !pix);

    // R4
    msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (pix == $past(in_data[WORD_W-1])));

    // R6
    rewind_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_rewind |-> (vsync && line_start));

    // R3
    ready_vis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> vis_q);

endmodule

// File: tb/mono_vga_streamer_bench.sv
module mono_vga_streamer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W   = 32;
    localparam int HA  = 64;
    localparam int HFP = 4;
    localparam int HS  = 8;
    localparam int HBP = 4;
    localparam int VA  = 6;
    localparam int VFP = 1;
    localparam int VS  = 2;
    localparam int VBP = 2;
    localparam int HT  = HA + HFP + HS + HBP;
    localparam int VT  = VA + VFP + VS + VBP;
    localparam int FR  = HT * VT;
    localparam int WPL = HA / W;
    localparam int NCYC = 3 * FR + 4;
    localparam int WD_CYC = NCYC + 2000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         in_ready, pix, hsync_n, vsync, line_start, frame_rewind, underrun;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mono_vga_streamer #(
        .WORD_W(W), .H_VIS(HA), .H_FRONT(HFP), .H_PULSE(HS), .H_BACK(HBP),
        .V_VIS(VA), .V_FRONT(VFP), .V_PULSE(VS), .V_BACK(VBP)
    ) u_mono_vga_streamer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .pix(pix), .hsync_n(hsync_n), .vsync(vsync),
        .line_start(line_start), .frame_rewind(frame_rewind), .underrun(underrun)
    );

    function automatic logic [W-1:0] pat(input int f, input int w);
        if (f == 0) return '1;
        return (32'(w + 1) * 32'h9E3779B1) ^ (32'(f) << 8);
    endfunction

    function automatic bit starve(input int f, input int w);
        return (f == 2) && ((w % 5) == 1 || w == WPL * VA - 1);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int  ptr;
        int  fsrc;
        bit  und_exp;
        ptr = 0;
        fsrc = 0;
        und_exp = 1'b0;
        repeat (3) @(negedge clk);
        // R9: outputs while reset is held
        chk("R9 pix in reset", 32'(pix), 0);
        chk("R9 hsync_n in reset", 32'(hsync_n), 1);
        chk("R9 vsync in reset", 32'(vsync), 0);
        chk("R9 line_start in reset", 32'(line_start), 0);
        chk("R9 frame_rewind in reset", 32'(frame_rewind), 0);
        chk("R9 underrun in reset", 32'(underrun), 0);
        rst_n = 1'b1;
        for (int k = 0; k <= NCYC; k++) begin
            int  h, v, f, widx;
            bit  rdy;
            if (k >= 1) begin
                int p, ph, pv, pf, pw;
                bit vis, slot;
                logic [W-1:0] wd;
                logic exp_pix;
                p  = k - 1;
                ph = p % HT;
                pv = (p / HT) % VT;
                pf = p / FR;
                pw = pv * WPL + ph / W;
                vis  = (ph < HA) && (pv < VA);
                slot = vis && (ph % W == 0);
                wd = pat(pf, pw);
                exp_pix = vis && !starve(pf, pw) && wd[W - 1 - (ph % W)];
                if (!vis)                chk("R5 blank pixel", 32'(pix), 0);
                else if (starve(pf, pw)) chk("R7 starved slot pixel", 32'(pix), 0);
                else                     chk("R4 pixel bit order", 32'(pix), 32'(exp_pix));
                chk("R1 hsync_n", 32'(hsync_n),
                    32'(!(ph >= HA + HFP && ph < HA + HFP + HS)));
                chk("R1 line_start", 32'(line_start), 32'(ph == 0));
                chk("R2 vsync", 32'(vsync), 32'(pv >= VA + VFP && pv < VA + VFP + VS));
                chk("R6 frame_rewind", 32'(frame_rewind), 32'(ph == 0 && pv == VA + VFP));
                if (ph == 0 && pv == VA + VFP) und_exp = 1'b0;
                else if (slot && starve(pf, pw)) und_exp = 1'b1;
                chk("R7 underrun flag", 32'(underrun), 32'(und_exp));
                if (frame_rewind) begin
                    ptr = 0;
                    fsrc++;
                end
            end
            h = k % HT;
            v = (k / HT) % VT;
            f = k / FR;
            widx = v * WPL + h / W;
            rdy = (h < HA) && (v < VA) && (h % W == 0);
            if (rdy) begin
                in_valid = !starve(f, widx);
                in_data  = pat(fsrc, ptr);
            end else begin
                // R8: valid garbage offered while not ready
                in_valid = 1'b1;
                in_data  = 32'(k) * 32'h01234567 ^ 32'h5A5AA5A5;
            end
            #1;
            chk("R3 in_ready", 32'(in_ready), 32'(rdy));
            if (rdy) ptr++;
            @(posedge clk);
            @(negedge clk);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

endmodule